// File: doc/BRIEF.md
# Segment Limit Bounds Checker

This block decides whether a memory access lies inside a segment. A request carries the 20-bit raw limit field of a segment descriptor, together with the granularity, expand-down and big flags, a 32-bit offset and an access size. The block first widens the raw field to a 32-bit byte-granular limit. It then tests every byte of the access against the valid range for the segment's direction. For an expand-up segment that range runs from zero to the limit. For an expand-down segment it runs from just above the limit to a top bound that the big flag selects. A limit-loading query can take the widened limit straight from the response.

A second mode checks a descriptor-table selector index instead of an offset. The raw limit then describes a table of eight-byte entries, and the block faults the selector when the last byte of the chosen entry lies past the table limit. Both modes share one request strobe. The verdict and the widened limit come back one clock later, registered, with their own valid flag. Descriptor fetch, privilege rules and exception delivery happen outside this block.

Top module: `seglim_checker`

## Requirements
- R1: With granularity 0, the returned limit equals the 20-bit raw field zero-extended to 32 bits.
- R2: With granularity 1, the returned limit is the raw field shifted left by 12 with the low 12 bits set to one (range 0xFFF to 0xFFFFFFFF).
- R3: In segment mode (mode 0) on an expand-up segment (expand-down flag 0), a single-byte access at any offset from 0 to the limit inclusive does not fault, and one above the limit faults.
- R4: An access faults unless every byte from offset to offset+size-1 is within bounds. Size code 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes. A span that would pass 0xFFFFFFFF faults and does not wrap.
- R5: On an expand-down segment (expand-down flag 1), any access whose offset is at or below the limit faults.
- R6: On an expand-down segment, the last byte of the access must not exceed 0xFFFF when the big flag is 0, or 0xFFFFFFFF when it is 1.
- R7: An expand-down segment with limit 0 accepts every offset from 1 up to its top bound. One whose limit is 0xFFFFFFFF faults on every offset.
- R8: In table mode (mode 1), a selector index i faults exactly when i*8+7 exceeds the returned limit. Offset, size and direction are ignored in this mode.
- R9: In segment mode, size code 3 always faults.
- R10: The response valid flag rises exactly one cycle after each request strobe and is low otherwise. Fault and limit hold their values while no request arrives.
- R11: After reset, the response valid flag, fault and limit are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 1 | 0 = segment offset check, 1 = table selector check |
| lim_raw | input | 20 | Raw descriptor limit field |
| gran | input | 1 | Granularity flag (1 = 4 KiB units) |
| exp_down | input | 1 | Expand-down direction flag |
| big | input | 1 | Selects 32-bit top bound for expand-down |
| offset | input | 32 | Byte offset of the access |
| size_code | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| sel_index | input | 13 | Descriptor-table selector index |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_fault | output | 1 | Access or selector is out of bounds |
| rsp_limit | output | 32 | Widened byte-granular limit |

## Verification
The bench builds the block with its default parameters: a 20-bit limit field, a 12-bit granularity shift, a 32-bit offset, a 16-bit small top bound and 13-bit indices into 8-byte entries. With these values the stimulus can reach the full 4 GiB corner, where a 4-byte access near 0xFFFFFFFF would wrap, as well as the 64 KiB top bound of small expand-down segments. They also cover a 512-entry table produced by a granular limit of 0xFFF. Requests are issued back to back across all four combinations of direction and granularity, at offsets equal to the limit, one above it, and at the top of each range.

// File: rtl/seglim_pkg.sv
// Package: shared encodings for the segment limit checker.
// Assumes: nothing beyond standard SystemVerilog.
package seglim_pkg;

    // Selects what a request checks
    typedef enum logic {
        CHK_SEGMENT = 1'b0,
        CHK_TABLE   = 1'b1
    } chk_mode_e;

    // Access width encoding carried on size_code
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } acc_size_e;

endpackage

// File: rtl/seglim_expand.sv
// Module: seglim_expand
// Widens the raw descriptor limit field to a byte-granular limit.
// Granular form shifts the field up by GRAN_SHIFT and fills ones below.
// Assumes ADDR_W >= LIMIT_W; excess high bits of the granular form are dropped.
module seglim_expand #(
    parameter int LIMIT_W    = 20,
    parameter int ADDR_W     = 32,
    parameter int GRAN_SHIFT = 12
) (
    input  logic [LIMIT_W-1:0] lim_raw,
    input  logic               gran,
    output logic [ADDR_W-1:0]  eff_limit
);
    localparam int WIDE_W = ADDR_W + LIMIT_W + GRAN_SHIFT;

    logic [WIDE_W-1:0] coarse_wide;
    logic [WIDE_W-1:0] fine_wide;

    // Build both interpretations in a common wide vector
    always_comb begin
        coarse_wide = {{ADDR_W{1'b0}}, lim_raw, {GRAN_SHIFT{1'b1}}};
        fine_wide   = {{(ADDR_W+GRAN_SHIFT){1'b0}}, lim_raw};
    end

    // Pick the interpretation named by the granularity flag
    always_comb begin
        eff_limit = gran ? coarse_wide[ADDR_W-1:0] : fine_wide[ADDR_W-1:0];
    end
endmodule

// File: rtl/seglim_bounds.sv
// Module: seglim_bounds
// Tests a multi-byte access against an expand-up or expand-down segment.
// Uses an ADDR_W+1 bit sum so that a span past the top never wraps.
// Assumes SMALL_TOP_W < ADDR_W.
module seglim_bounds
    import seglim_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SMALL_TOP_W = 16
) (
    input  logic [ADDR_W-1:0] eff_limit,
    input  logic              exp_down,
    input  logic              big,
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        size_code,
    output logic              fault
);
    localparam int EXT_W = ADDR_W + 1;
    localparam logic [EXT_W-1:0] SMALL_TOP =
        {{(EXT_W-SMALL_TOP_W){1'b0}}, {SMALL_TOP_W{1'b1}}};
    localparam logic [EXT_W-1:0] LARGE_TOP = {1'b0, {ADDR_W{1'b1}}};

    logic [2:0]       span_add;
    logic             bad_size;
    logic [EXT_W-1:0] offset_ext;
    logic [EXT_W-1:0] limit_ext;
    logic [EXT_W-1:0] span_last;
    logic [EXT_W-1:0] lower_ext;
    logic [EXT_W-1:0] upper_ext;
    logic             up_fault;
    logic             down_fault;

    // Decode access size into the distance to its last byte
    always_comb begin
        bad_size = 1'b0;
        unique case (acc_size_e'(size_code))
            SZ_BYTE:  span_add = 3'd0;
            SZ_WORD:  span_add = 3'd1;
            SZ_DWORD: span_add = 3'd3;
            default: begin
                span_add = 3'd0;
                bad_size = 1'b1;
            end
        endcase
    end

    // Form the extended first byte, last byte and bounds
    always_comb begin
        offset_ext = {1'b0, offset};
        limit_ext  = {1'b0, eff_limit};
        span_last  = offset_ext + {{(EXT_W-3){1'b0}}, span_add};
        lower_ext  = limit_ext + {{(EXT_W-1){1'b0}}, 1'b1};
        upper_ext  = big ? LARGE_TOP : SMALL_TOP;
    end

    // Compare against the range of each direction and merge
    always_comb begin
        up_fault   = span_last > limit_ext;
        down_fault = (offset_ext < lower_ext) || (span_last > upper_ext);
        fault      = bad_size | (exp_down ? down_fault : up_fault);
    end
endmodule

// File: rtl/seglim_table.sv
// Module: seglim_table
// Checks that the whole entry picked by a selector index lies within a
// descriptor-table limit. Entries are 2**ENTRY_LOG2 bytes.
// Assumes IDX_W + ENTRY_LOG2 <= ADDR_W.
module seglim_table #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 13,
    parameter int ENTRY_LOG2 = 3
) (
    input  logic [ADDR_W-1:0] eff_limit,
    input  logic [IDX_W-1:0]  sel_index,
    output logic              fault
);
    localparam int LAST_W = IDX_W + ENTRY_LOG2;

    logic [LAST_W-1:0] entry_last;
    logic [ADDR_W-1:0] entry_last_ext;

    // Address of the final byte of the selected entry
    always_comb begin
        entry_last     = {sel_index, {ENTRY_LOG2{1'b1}}};
        entry_last_ext = {{(ADDR_W-LAST_W){1'b0}}, entry_last};
    end

    // Fault when that byte lies past the table limit
    always_comb begin
        fault = entry_last_ext > eff_limit;
    end
endmodule

// File: rtl/seglim_checker.sv
// Module: seglim_checker (top)
// Registered segment / table limit checker. A request on req_valid gives
// rsp_fault and rsp_limit one cycle later with rsp_valid. The outputs hold
// between requests.
// Assumes a synchronous active-low reset and one request per cycle at most.
module seglim_checker
    import seglim_pkg::*;
#(
    parameter int LIMIT_W     = 20,
    parameter int ADDR_W      = 32,
    parameter int GRAN_SHIFT  = 12,
    parameter int SMALL_TOP_W = 16,
    parameter int IDX_W       = 13,
    parameter int ENTRY_LOG2  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_mode,
    input  logic [LIMIT_W-1:0] lim_raw,
    input  logic               gran,
    input  logic               exp_down,
    input  logic               big,
    input  logic [ADDR_W-1:0]  offset,
    input  logic [1:0]         size_code,
    input  logic [IDX_W-1:0]   sel_index,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [ADDR_W-1:0]  rsp_limit
);
    logic [ADDR_W-1:0] eff_limit;
    logic              seg_fault;
    logic              tbl_fault;
    logic              next_fault;

    seglim_expand #(
        .LIMIT_W    (LIMIT_W),
        .ADDR_W     (ADDR_W),
        .GRAN_SHIFT (GRAN_SHIFT)
    ) u_expand (
        .lim_raw   (lim_raw),
        .gran      (gran),
        .eff_limit (eff_limit)
    );

    seglim_bounds #(
        .ADDR_W      (ADDR_W),
        .SMALL_TOP_W (SMALL_TOP_W)
    ) u_bounds (
        .eff_limit (eff_limit),
        .exp_down  (exp_down),
        .big       (big),
        .offset    (offset),
        .size_code (size_code),
        .fault     (seg_fault)
    );

    seglim_table #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .ENTRY_LOG2 (ENTRY_LOG2)
    ) u_table (
        .eff_limit (eff_limit),
        .sel_index (sel_index),
        .fault     (tbl_fault)
    );

    // Choose the verdict of the requested mode
    always_comb begin
        next_fault = (chk_mode_e'(req_mode) == CHK_TABLE) ? tbl_fault : seg_fault;
    end

    // Response valid follows the strobe by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // Capture verdict and widened limit only on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_fault <= 1'b0;
            rsp_limit <= '0;
        end else if (req_valid) begin
            rsp_fault <= next_fault;
            rsp_limit <= eff_limit;
        end
    end
endmodule

// File: rtl/seglim_checker_sva.sv
// Module: seglim_checker_sva
// Property checker bound to seglim_checker; observes ports only.
module seglim_checker_sva #(
    parameter int LIMIT_W    = 20,
    parameter int ADDR_W     = 32,
    parameter int GRAN_SHIFT = 12,
    parameter int IDX_W      = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_mode,
    input logic [LIMIT_W-1:0] lim_raw,
    input logic               gran,
    input logic               exp_down,
    input logic               big,
    input logic [ADDR_W-1:0]  offset,
    input logic [1:0]         size_code,
    input logic [IDX_W-1:0]   sel_index,
    input logic               rsp_valid,
    input logic               rsp_fault,
    input logic [ADDR_W-1:0]  rsp_limit
);
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_fault) && $stable(rsp_limit)));

    assert_fine_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !gran) |=> (rsp_limit == ADDR_W'($past(lim_raw))));

    assert_coarse_low_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && gran) |=> (rsp_limit[GRAN_SHIFT-1:0] == {GRAN_SHIFT{1'b1}}));

    assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_mode && size_code == 2'd3) |=> rsp_fault);

    assert_up_origin_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_mode && !exp_down && size_code == 2'd0 && offset == '0)
        |=> !rsp_fault);

    assert_down_origin_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_mode && exp_down && offset == '0) |=> rsp_fault);

    assert_down_full_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_mode && exp_down && gran && lim_raw == {LIMIT_W{1'b1}})
        |=> rsp_fault);

    assert_table_first_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode && gran && sel_index == '0) |=> !rsp_fault);
endmodule

bind seglim_checker seglim_checker_sva #(
    .LIMIT_W    (LIMIT_W),
    .ADDR_W     (ADDR_W),
    .GRAN_SHIFT (GRAN_SHIFT),
    .IDX_W      (IDX_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .lim_raw   (lim_raw),
    .gran      (gran),
    .exp_down  (exp_down),
    .big       (big),
    .offset    (offset),
    .size_code (size_code),
    .sel_index (sel_index),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_limit (rsp_limit)
);

// File: tb/seglim_checker_tb.sv
// Scoreboard bench: drive_req pushes expected results, a monitor pops and compares.
module seglim_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_mode = 1'b0;
    logic [19:0] lim_raw = '0;
    logic        gran = 1'b0;
    logic        exp_down = 1'b0;
    logic        big = 1'b0;
    logic [31:0] offset = '0;
    logic [1:0]  size_code = '0;
    logic [12:0] sel_index = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_limit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic        fault;
        logic [31:0] limit;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t last_exp;

    always #4 clk = ~clk;

    seglim_checker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .lim_raw(lim_raw), .gran(gran), .exp_down(exp_down), .big(big),
        .offset(offset), .size_code(size_code), .sel_index(sel_index),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_limit(rsp_limit)
    );

    // Independent reference model of the requirements
    function automatic exp_t model(input logic m, input logic [19:0] raw, input logic g,
                                   input logic ed, input logic b, input logic [31:0] off,
                                   input logic [1:0] sc, input logic [12:0] idx,
                                   input string tag);
        exp_t e;
        longint lim, last, top, nbytes, entry_end;
        lim = g ? ((longint'(raw) << 12) + 4095) : longint'(raw);
        e.limit = lim[31:0];
        e.tag = tag;
        if (m) begin
            entry_end = longint'(idx) * 8 + 7;
            e.fault = entry_end > lim;
        end else if (sc == 2'd3) begin
            e.fault = 1'b1;
        end else begin
            nbytes = (sc == 2'd0) ? 1 : (sc == 2'd1) ? 2 : 4;
            last = longint'(off) + nbytes - 1;
            top = b ? 64'hFFFF_FFFF : 64'hFFFF;
            if (ed) e.fault = (longint'(off) <= lim) || (last > top);
            else    e.fault = last > lim;
        end
        return e;
    endfunction

    task automatic fail_line(input string tag, input string what,
                             input longint act, input longint expv);
        fails++;
        $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    endtask

    // Driver: apply one request for one cycle, back to back when called in a row
    task automatic drive_req(input logic m, input logic [19:0] raw, input logic g,
                             input logic ed, input logic b, input logic [31:0] off,
                             input logic [1:0] sc, input logic [12:0] idx,
                             input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; lim_raw = raw; gran = g; exp_down = ed;
        big = b; offset = off; size_code = sc; sel_index = idx;
        sb_q.push_back(model(m, raw, g, ed, b, off, sc, idx, tag));
    endtask

    task automatic go_idle();
        @(negedge clk);
        req_valid = 1'b0;
        offset = 32'hDEAD_BEEF; lim_raw = 20'h5A5A5; gran = ~gran;
    endtask

    // Monitor: compare each response with the front of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                checks++;
                if (sb_q.size() == 0) begin
                    fail_line("R10", "unexpected valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    last_exp = e;
                    if (rsp_fault !== e.fault || rsp_limit !== e.limit) begin
                        fail_line(e.tag, "fault", longint'(rsp_fault), longint'(e.fault));
                        $display("FAIL %s limit: actual 0x%0h expected 0x%0h",
                                 e.tag, rsp_limit, e.limit);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fail_line("WATCHDOG", "timeout", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        checks++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_limit !== 32'd0)
            fail_line("R11", "reset outputs", {rsp_valid, rsp_fault, rsp_limit}, 0);
        rst_n = 1'b1;

        // R1 / R3 / R4: expand-up, fine granularity, limit 0x100
        drive_req(0, 20'h00100, 0, 0, 0, 32'h100, 0, 0, "R3");
        drive_req(0, 20'h00100, 0, 0, 0, 32'h101, 0, 0, "R3");
        drive_req(0, 20'h00100, 0, 0, 0, 32'h0FF, 1, 0, "R4");
        drive_req(0, 20'h00100, 0, 0, 0, 32'h0FF, 2, 0, "R4");
        drive_req(0, 20'h00000, 0, 0, 0, 32'h0, 0, 0, "R1");
        drive_req(0, 20'h00000, 0, 0, 0, 32'h0, 1, 0, "R4");
        drive_req(0, 20'hFFFFF, 0, 0, 1, 32'hFFFFF, 0, 0, "R1");
        // R2 / R3 / R4: expand-up, coarse granularity
        drive_req(0, 20'hFFFFF, 1, 0, 0, 32'hFFFF_FFFF, 0, 0, "R2");
        drive_req(0, 20'hFFFFF, 1, 0, 0, 32'hFFFF_FFFE, 2, 0, "R4");
        drive_req(0, 20'hFFFFF, 1, 0, 0, 32'hFFFF_FFFC, 2, 0, "R4");
        drive_req(0, 20'h00001, 1, 0, 0, 32'h1FFF, 0, 0, "R3");
        drive_req(0, 20'h00001, 1, 0, 0, 32'h2000, 0, 0, "R3");
        drive_req(0, 20'h00000, 1, 0, 0, 32'hFFF, 0, 0, "R2");
        // R5 / R6: expand-down, fine granularity, small top
        drive_req(0, 20'h00FFF, 0, 1, 0, 32'hFFF, 0, 0, "R5");
        drive_req(0, 20'h00FFF, 0, 1, 0, 32'h1000, 0, 0, "R5");
        drive_req(0, 20'h00FFF, 0, 1, 0, 32'hFFFF, 0, 0, "R6");
        drive_req(0, 20'h00FFF, 0, 1, 0, 32'hFFFF, 1, 0, "R6");
        drive_req(0, 20'h00FFF, 0, 1, 0, 32'h10000, 0, 0, "R6");
        drive_req(0, 20'h00FFF, 0, 1, 1, 32'h10000, 0, 0, "R6");
        // R5 / R6: expand-down, coarse granularity, big top
        drive_req(0, 20'h00010, 1, 1, 1, 32'h10FFF, 0, 0, "R5");
        drive_req(0, 20'h00010, 1, 1, 1, 32'h11000, 2, 0, "R5");
        drive_req(0, 20'h00010, 1, 1, 1, 32'hFFFF_FFFF, 0, 0, "R6");
        drive_req(0, 20'h00010, 1, 1, 1, 32'hFFFF_FFFD, 2, 0, "R6");
        // R7: extremes of expand-down size
        drive_req(0, 20'h00000, 0, 1, 1, 32'h0, 0, 0, "R7");
        drive_req(0, 20'h00000, 0, 1, 1, 32'h1, 0, 0, "R7");
        drive_req(0, 20'h00000, 0, 1, 0, 32'hFFFC, 2, 0, "R7");
        drive_req(0, 20'hFFFFF, 1, 1, 1, 32'hFFFF_FFFF, 0, 0, "R7");
        drive_req(0, 20'hFFFFF, 1, 1, 1, 32'h8000_0000, 0, 0, "R7");
        // R9: illegal size
        drive_req(0, 20'hFFFFF, 1, 0, 0, 32'h0, 3, 0, "R9");
        drive_req(0, 20'h00000, 0, 1, 1, 32'h100, 3, 0, "R9");
        // R8: table mode, direction/size/offset ignored
        drive_req(1, 20'h00017, 0, 0, 0, 32'h0, 0, 13'd2, "R8");
        drive_req(1, 20'h00017, 0, 1, 0, 32'hFFFF_FFFF, 3, 13'd3, "R8");
        drive_req(1, 20'h00017, 0, 1, 1, 32'h0, 3, 13'd0, "R8");
        drive_req(1, 20'h00000, 0, 0, 0, 32'h0, 0, 13'd0, "R8");
        drive_req(1, 20'h00000, 1, 0, 0, 32'h0, 0, 13'd511, "R8");
        drive_req(1, 20'h00000, 1, 1, 0, 32'h0, 2, 13'd512, "R8");
        drive_req(1, 20'hFFFFF, 1, 0, 0, 32'h0, 0, 13'd8191, "R8");
        go_idle();
        repeat (4) @(negedge clk);

        // R10: outputs hold while idle, nothing left outstanding
        checks++;
        if (rsp_fault !== last_exp.fault || rsp_limit !== last_exp.limit)
            fail_line("R10", "hold limit", longint'(rsp_limit), longint'(last_exp.limit));
        checks++;
        if (sb_q.size() != 0)
            fail_line("R10", "missing responses", sb_q.size(), 0);

        // R10: a single isolated request after idle
        drive_req(0, 20'h00200, 0, 0, 0, 32'h201, 0, 0, "R10");
        go_idle();
        repeat (3) @(negedge clk);
        checks++;
        if (sb_q.size() != 0)
            fail_line("R10", "missing response", sb_q.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule